// File: doc/BRIEF.md
# Stochastic N-th Root with Output Feedback

This block takes a unipolar stochastic bitstream, one bit per clock, and returns a stream whose density of 1s approaches the N-th root of the input density. N is a parameter of 2 or more; N=3 gives a cube root. It needs no polynomial approximation. The output is the input stream with extra 1s placed into slots where the input bit is 0. A feedback term decides when a 1 is owed. That term is the current output bit ANDed with the complement of an estimate of P_out^(N-1). The estimate is the AND of N-1 reshuffled copies of the block's own past output. At equilibrium P_out = P_in + P_out·(1 − P_out^(N-1)), which gives P_in = P_out^N.

Each reshuffled copy comes from a small swap buffer. A pseudo-random index picks one stored bit to send out, and the newest output bit takes its place. Every copy has its own linear feedback shift register with a distinct nonzero seed, so the copies are only weakly correlated with each other and with the live stream. Feedback 1s that arrive while the input bit is already 1 are held in a small saturating credit counter. They are spent later in empty input slots. The surrounding system converts binary values into streams and counts the output 1s.

Top module: `sroot_nth`

## Requirements
- R1: After the asynchronous reset is released, out_bit and out_vld are 0.
- R2: out_vld equals the value in_vld had one clock earlier, unless clr was high in that cycle.
- R3: When in_vld and in_bit are both 1 (and clr is 0), out_bit is 1 in the next cycle. The output never drops an input 1.
- R4: With in_vld high and in_bit always 0, starting from reset or clear, out_bit stays 0.
- R5: With in_vld high and in_bit always 1, out_bit is 1 in every cycle.
- R6: With the default N=3, after a settling time of 512 accepted bits, the number of 1s over the next 256 accepted bits is within 51 of round(256·(k/256)^(1/3)). Here k is the number of 1s in each 256-bit period of the input.
- R7: Built with N=2, the block meets the same bound against round(256·(k/256)^(1/2)).
- R8: While in_vld is 0, out_bit holds its value and out_vld is 0. The internal state does not advance.
- R9: A cycle with clr high sets out_bit and out_vld to 0 in the next cycle. It also empties the credit counter, the swap buffers and the output history, and reseeds the random sources. An all-zero input that follows then yields only 0s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all stream state |
| in_vld | input | 1 | Input bit is present this cycle |
| in_bit | input | 1 | Input stream bit |
| out_vld | output | 1 | Output bit is new this cycle |
| out_bit | output | 1 | Output stream bit |

## Verification
The hardest state to reach from the ports is a nonzero credit counter at a moment when no new feedback can arrive. Only that state shows whether a clear really empties the hidden history. The bench first runs a dense input long enough to build up credit and a 1-rich swap history. It then pulses clr and follows with an all-zero stream. Any leftover credit or history would show up as stray 1s. A second hard point is the settled density, which is only defined statistically. The input patterns use a bit-reversed counter compare, so each 256-bit window holds exactly k 1s, spread evenly. The output count can then be judged against the real root.

// File: rtl/sroot_pkg.sv
package sroot_pkg;

  localparam int unsigned SEED_W = 32;
  typedef logic [SEED_W-1:0] seed_t;

  // Distinct, always-odd seed per decorrelation copy so no LFSR starts at zero.
  function automatic seed_t seed_of(input int unsigned copy);
    seed_t s;
    s = 32'h5A3C_ACE1 + (seed_t'(copy) * 32'h0007_1F35);
    return s | seed_t'(1);
  endfunction

endpackage

// File: rtl/sroot_lfsr.sv
module sroot_lfsr #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] state
);

  logic [W-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (clr) begin
      state_d = SEED;
    end else if (en) begin
      state_d = state_q[0] ? ((state_q >> 1) ^ TAPS) : (state_q >> 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R9 / R6: random source never locks up in the all-zero state
  a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

endmodule

// File: rtl/sroot_reorder.sv
module sroot_reorder #(
  parameter int unsigned D  = 5,
  parameter int unsigned IW = (D > 1) ? $clog2(D) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          din,
  input  logic [IW-1:0] rnd,
  output logic          dout
);

  logic [D-1:0]  buf_q, buf_d;
  logic [IW-1:0] idx;

  // Fold the random value into 0..D-1
  always_comb begin
    if (32'(rnd) < D) idx = rnd;
    else              idx = IW'(32'(rnd) - D);
  end

  assign dout = buf_q[idx];

  always_comb begin
    buf_d = buf_q;
    if (clr) begin
      buf_d = '0;
    end else if (en) begin
      buf_d[idx] = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_q <= '0;
    else        buf_q <= buf_d;
  end

  // R9: a clear leaves no history behind
  a_r9_buf_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (buf_q == '0));

  // R8: without an enable the stored history does not move
  a_r8_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(buf_q));

endmodule

// File: rtl/sroot_power.sv
module sroot_power #(
  parameter int unsigned N    = 3,
  parameter int unsigned D    = 5,
  parameter int unsigned LW   = 16,
  parameter logic [LW-1:0] TAPS = 16'hB400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic din,
  output logic pow
);

  localparam int unsigned COPIES = N - 1;
  localparam int unsigned IW     = (D > 1) ? $clog2(D) : 1;

  logic [COPIES-1:0] copy_bit;

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    localparam sroot_pkg::seed_t SF = sroot_pkg::seed_of(c);
    localparam logic [LW-1:0]    S  = SF[LW-1:0];

    logic [LW-1:0] rnd_state;

    sroot_lfsr #(.W(LW), .TAPS(TAPS), .SEED(S)) i_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .en    (en),
      .state (rnd_state)
    );

    sroot_reorder #(.D(D), .IW(IW)) i_reorder (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .en    (en),
      .din   (din),
      .rnd   (rnd_state[IW-1:0]),
      .dout  (copy_bit[c])
    );
  end

  assign pow = &copy_bit;

endmodule

// File: rtl/sroot_nsadd.sv
module sroot_nsadd #(
  parameter int unsigned CW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic in_bit,
  input  logic fb,
  output logic out_bit
);

  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (clr) begin
      cnt_d = '0;
      out_d = 1'b0;
    end else if (en) begin
      if (in_bit) begin
        out_d = 1'b1;
        if (fb && (cnt_q != CMAX)) cnt_d = cnt_q + 1'b1;
      end else if (fb) begin
        out_d = 1'b1;
      end else if (cnt_q != '0) begin
        out_d = 1'b1;
        cnt_d = cnt_q - 1'b1;
      end else begin
        out_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign out_bit = out_q;

  // R6: the credit counter saturates instead of wrapping
  a_r6_credit_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && in_bit && fb && (cnt_q == CMAX)) |=> (cnt_q == CMAX));

  // R3: an input 1 always reaches the output
  a_r3_one_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && in_bit) |=> out_q);

  // R9: clear empties the credit
  a_r9_credit_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && !out_q);

endmodule

// File: rtl/sroot_nth.sv
module sroot_nth #(
  parameter int unsigned N    = 3,
  parameter int unsigned D    = 5,
  parameter int unsigned LW   = 16,
  parameter logic [LW-1:0] TAPS = 16'hB400,
  parameter int unsigned CW   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic in_vld,
  input  logic in_bit,
  output logic out_vld,
  output logic out_bit
);

  logic pow;
  logic fb;
  logic vld_q, vld_d;

  sroot_power #(.N(N), .D(D), .LW(LW), .TAPS(TAPS)) i_power (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .en    (in_vld),
    .din   (out_bit),
    .pow   (pow)
  );

  // Owed insertion: current output is 1 and the power estimate is 0
  assign fb = out_bit & ~pow;

  sroot_nsadd #(.CW(CW)) i_nsadd (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .en      (in_vld),
    .in_bit  (in_bit),
    .fb      (fb),
    .out_bit (out_bit)
  );

  always_comb begin
    vld_d = clr ? 1'b0 : in_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign out_vld = vld_q;

  // R2: valid strobe follows the input strobe by one cycle
  a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (out_vld == $past(in_vld)));

  // R8: output holds while no input bit is offered
  a_r8_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_vld && !clr) |=> ($stable(out_bit) && !out_vld));

  // R9: clear forces a quiet output
  a_r9_clr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!out_bit && !out_vld));

endmodule

// File: tb/test_sroot_nth.sv
`timescale 1ns/1ps
module test_sroot_nth;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic in_vld = 1'b0;
  logic in_bit = 1'b0;
  logic out_vld, out_bit;
  logic out_vld2, out_bit2;

  int errors = 0;
  int checks = 0;
  int phase = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sroot_nth #(.N(3)) i_sroot_nth (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .in_vld(in_vld), .in_bit(in_bit),
    .out_vld(out_vld), .out_bit(out_bit)
  );

  sroot_nth #(.N(2)) i_sroot_nth_n2 (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .in_vld(in_vld), .in_bit(in_bit),
    .out_vld(out_vld2), .out_bit(out_bit2)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Exactly k ones per 256-bit period, evenly spread
  function automatic bit pat(input int i, input int k);
    logic [7:0] a, r;
    a = 8'(i % 256);
    for (int b = 0; b < 8; b++) r[b] = a[7-b];
    return int'(r) < k;
  endfunction

  // Drive one cycle away from the edge; outputs sampled 1 ns after the edge
  task automatic cyc(input bit v, input bit b, input bit c);
    in_vld = v; in_bit = b; clr = c;
    @(posedge clk);
    #1;
  endtask

  function automatic int root_exp(input int k, input int n);
    real x;
    x = real'(k) / 256.0;
    return int'($floor(256.0 * (x ** (1.0 / real'(n))) + 0.5));
  endfunction

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(out_bit == 1'b0, "R1 out_bit", int'(out_bit), 0);
    check(out_vld == 1'b0, "R1 out_vld", int'(out_vld), 0);
  endtask

  // Run a density-k stream; count ones over a settled 256-bit window
  task automatic t_stream(input int k, input bit exact);
    int c3 = 0, c2 = 0, miss = 0, vbad = 0;
    int e3, e2, d3, d2;
    phase = 0;
    for (int i = 0; i < 768; i++) begin
      bit b = pat(phase, k);
      cyc(1'b1, b, 1'b0);
      phase++;
      if (b && !(out_bit && out_bit2)) miss++;
      if (!out_vld || !out_vld2) vbad++;
      if (i >= 512) begin
        c3 += int'(out_bit);
        c2 += int'(out_bit2);
      end
    end
    e3 = root_exp(k, 3);
    e2 = root_exp(k, 2);
    d3 = (c3 > e3) ? c3 - e3 : e3 - c3;
    d2 = (c2 > e2) ? c2 - e2 : e2 - c2;
    check(miss == 0, "R3 input ones kept", miss, 0);
    check(vbad == 0, "R2 out_vld follows in_vld", vbad, 0);
    check(c3 >= k, "R3 N=3 count not below input", c3, k);
    if (exact) begin
      if (k == 0) begin
        check(c3 == 0, "R4 zero input N=3", c3, 0);
        check(c2 == 0, "R4 zero input N=2", c2, 0);
      end else begin
        check(c3 == 256, "R5 full input N=3", c3, 256);
        check(c2 == 256, "R5 full input N=2", c2, 256);
      end
    end else begin
      check(d3 <= 51, "R6 cube root count", c3, e3);
      check(d2 <= 51, "R7 square root count", c2, e2);
    end
  endtask

  task automatic t_hold;
    bit h3, h2;
    int bad = 0, vb = 0;
    for (int i = 0; i < 40; i++) cyc(1'b1, pat(i, 180), 1'b0);
    h3 = out_bit; h2 = out_bit2;
    for (int i = 0; i < 12; i++) begin
      cyc(1'b0, i[0], 1'b0);
      if (out_bit != h3 || out_bit2 != h2) bad++;
      if (out_vld || out_vld2) vb++;
    end
    check(bad == 0, "R8 output held without valid", bad, 0);
    check(vb == 0, "R8 out_vld low without valid", vb, 0);
    cyc(1'b1, 1'b1, 1'b0);
    check(out_vld && out_bit, "R2 resume after hold", int'(out_vld && out_bit), 1);
  endtask

  task automatic t_clear;
    int c3 = 0, c2 = 0;
    for (int i = 0; i < 300; i++) cyc(1'b1, pat(i, 230), 1'b0);
    cyc(1'b1, 1'b1, 1'b1);
    check(!out_bit && !out_vld, "R9 clear quiets output", int'(out_bit | out_vld), 0);
    for (int i = 0; i < 300; i++) begin
      cyc(1'b1, 1'b0, 1'b0);
      c3 += int'(out_bit);
      c2 += int'(out_bit2);
    end
    check(c3 == 0, "R9 no stale credit N=3", c3, 0);
    check(c2 == 0, "R9 no stale credit N=2", c2, 0);
  endtask

  initial begin
    t_reset();
    t_stream(0, 1'b1);
    t_stream(256, 1'b1);
    t_clear();
    t_stream(27, 1'b0);
    t_stream(64, 1'b0);
    t_stream(128, 1'b0);
    t_stream(216, 1'b0);
    t_hold();
    t_clear();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule